// File: doc/BRIEF.md
# RTC Flag and Wake-Up Controller

This block keeps the status flags and the control bits of a real-time clock. Three event sources report to it as single-cycle pulses: an alarm-time match, a kickstart, and a watchdog expiry. Each pulse sets a sticky flag that stays set until software clears it. The flags, gated by per-source interrupt enables, drive an open-drain interrupt output. A power-active bit drives an active-low wake-up power pin. Hardware pulls that bit low when an alarm arrives with wake enabled, or when a kickstart is pending.

Software reaches two byte-wide registers through a plain select/write-strobe port with a combinational read path. There is no streaming data here, so the port has no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high and is never stalled. The control register also drives the update-transfer enable, burst enable and crystal-select bits out to neighbouring logic. Only software writes change these bits.

Top module: `rtc_wake_ctrl`

## Requirements
- R1: After reset the status register reads 0x10, the control register reads 0x80, `pwr_oe` is 0, `irq_oe` is 0 and `xfer_en` is 1.
- R2: Control register (`reg_sel`=1): bit 7 transfer enable, bit 6 crystal select, bit 5 burst enable, bit 4 wake enable, bit 2 alarm interrupt enable, bit 1 kickstart interrupt enable, bit 0 watchdog interrupt enable. Bit 3 always reads 0.
- R3: Status register (`reg_sel`=0) bit 4 is the power-active bit, and software may write it either way. `pwr_oe` is 1 exactly when that bit is 0. `pwr_out` is always 0.
- R4: An `alarm_evt`, `kick_evt` or `wdog_evt` pulse sets status bit 3, bit 2 or bit 1 respectively, in the clock edge that samples it. A pulse in the same cycle as a status write that clears the flag still leaves the flag set.
- R5: While the kickstart flag is 1, or the alarm flag and wake enable are both 1, the power-active bit is cleared at the next edge. The clear overrides a software write of 1. While the alarm flag is 1, wake enable 0 and the kickstart flag 0, the bit is left alone.
- R6: Status bit 0 and `irq_oe` equal (alarm flag AND alarm enable) OR (kickstart flag AND kickstart enable) OR (watchdog flag AND watchdog enable), combinationally.
- R7: A status write loads bits 3..1 from `wr_data`: 1 sets a flag and 0 clears it. With no write and no event, a flag holds its value.
- R8: Only software writes change the transfer-enable bit. `xfer_en`, `burst_en` and `xtal_sel` follow control bits 7, 5 and 6.
- R9: A write to status bit 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = status register, 1 = control register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| alarm_evt | input | 1 | Alarm-match pulse |
| kick_evt | input | 1 | Kickstart pulse |
| wdog_evt | input | 1 | Watchdog-expiry pulse |
| pwr_oe | output | 1 | Power pin output enable (pin pulled low when 1) |
| pwr_out | output | 1 | Power pin data value, constant 0 |
| irq_oe | output | 1 | Interrupt pin open-drain enable (pin low when 1) |
| xfer_en | output | 1 | Update-transfer enable to the time counters |
| burst_en | output | 1 | Burst auto-increment enable to the RAM address logic |
| xtal_sel | output | 1 | Crystal load select to the oscillator |

## Verification
Two things can land in the same cycle: an event pulse and a software write that clears the same flag, and a hardware clear of the power-active bit and a software write that sets it. The bench pulses alarm and watchdog together with a status write of 0x10. The expected status is 0x1A, because the events win. It then writes 1 to the power-active bit while the kickstart flag is still set, and expects the bit to read back 0.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;
  // source index i maps to status bit i+1 and to enable bit i of control
  localparam int SRC_WDOG  = 0;
  localparam int SRC_KICK  = 1;
  localparam int SRC_ALARM = 2;
  // status bit positions
  localparam int ST_PWR  = 4;
  localparam int ST_IRQ  = 0;
  // control bit positions
  localparam int CT_TE   = 7;
  localparam int CT_XTAL = 6;
  localparam int CT_BRST = 5;
  localparam int CT_WAKE = 4;
  localparam logic [REG_W-1:0] CTRL_RST  = 8'h80;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'hF7;
endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  // an event wins over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (wr_en)   q <= wr_bit;
  end
endmodule

// File: rtl/rtc_pwr_bit.sv
module rtc_pwr_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr,
  input  logic wr_en,
  input  logic wr_bit,
  output logic pab
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pab <= 1'b1;
    else if (force_clr) pab <= 1'b0;
    else if (wr_en)     pab <= wr_bit;
  end
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int               W     = 8,
  parameter logic [W-1:0]     RST   = '0,
  parameter logic [W-1:0]     MASK  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST & MASK;
    else if (wr_en) q <= wr_data & MASK;
  end
endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  assign irq = |(flags & enables);
endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
  import rtc_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             alarm_evt,
  input  logic             kick_evt,
  input  logic             wdog_evt,
  output logic             pwr_oe,
  output logic             pwr_out,
  output logic             irq_oe,
  output logic             xfer_en,
  output logic             burst_en,
  output logic             xtal_sel
);
  logic               wr_stat, wr_ctl;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] flag_q;
  logic [REG_W-1:0]   ctrl_q;
  logic               pab_q;
  logic               irqf;
  logic               pwr_force;

  assign wr_stat = wr_en & ~reg_sel;
  assign wr_ctl  = wr_en &  reg_sel;

  assign evt_vec[SRC_WDOG]  = wdog_evt;
  assign evt_vec[SRC_KICK]  = kick_evt;
  assign evt_vec[SRC_ALARM] = alarm_evt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    rtc_flag_cell u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt_vec[i]),
      .wr_en   (wr_stat),
      .wr_bit  (wr_data[i+1]),
      .q       (flag_q[i])
    );
  end

  rtc_ctrl_reg #(.W(REG_W), .RST(CTRL_RST), .MASK(CTRL_MASK)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctl),
    .wr_data (wr_data),
    .q       (ctrl_q)
  );

  assign pwr_force = (flag_q[SRC_ALARM] & ctrl_q[CT_WAKE]) | flag_q[SRC_KICK];

  rtc_pwr_bit u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_clr (pwr_force),
    .wr_en     (wr_stat),
    .wr_bit    (wr_data[ST_PWR]),
    .pab       (pab_q)
  );

  rtc_irq_merge #(.N(NUM_SRC)) u_irq (
    .flags   (flag_q),
    .enables (ctrl_q[NUM_SRC-1:0]),
    .irq     (irqf)
  );

  always_comb begin
    if (reg_sel) begin
      rd_data = ctrl_q;
    end else begin
      rd_data = '0;
      rd_data[ST_PWR] = pab_q;
      rd_data[NUM_SRC:1] = flag_q;
      rd_data[ST_IRQ] = irqf;
    end
  end

  assign pwr_oe   = ~pab_q;
  assign pwr_out  = 1'b0;
  assign irq_oe   = irqf;
  assign xfer_en  = ctrl_q[CT_TE];
  assign burst_en = ctrl_q[CT_BRST];
  assign xtal_sel = ctrl_q[CT_XTAL];
endmodule

// File: rtl/rtc_wake_ctrl_chk.sv
module rtc_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       reg_sel,
  input logic       alarm_evt,
  input logic       kick_evt,
  input logic       wdog_evt,
  input logic [2:0] flag_q,
  input logic       pab_q,
  input logic       wake_en,
  input logic       irq_oe,
  input logic       xfer_en
);
  assert_alarm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flag_q[2]);
  assert_wdog_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> flag_q[0]);
  assert_kick_clears_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[1] |=> !pab_q);
  assert_wake_clears_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[2] && wake_en) |=> !pab_q);
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (flag_q != 3'b000));
  assert_kick_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !reg_sel) && !kick_evt) |=> $stable(flag_q[1]));
  assert_te_sw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_sel) |=> $stable(xfer_en));
endmodule

bind rtc_wake_ctrl rtc_wake_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .reg_sel   (reg_sel),
  .alarm_evt (alarm_evt),
  .kick_evt  (kick_evt),
  .wdog_evt  (wdog_evt),
  .flag_q    (flag_q),
  .pab_q     (pab_q),
  .wake_en   (ctrl_q[4]),
  .irq_oe    (irq_oe),
  .xfer_en   (xfer_en)
);

// File: tb/rtc_wake_ctrl_test.sv
`timescale 1ns/1ps
module rtc_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_evt = 1'b0, kick_evt = 1'b0, wdog_evt = 1'b0;
  logic       pwr_oe, pwr_out, irq_oe, xfer_en, burst_en, xtal_sel;

  int total = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;   // 0 status, 1 control, 2 pins {pwr_oe,irq_oe,xfer_en,burst_en}
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  rtc_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .alarm_evt(alarm_evt),
    .kick_evt(kick_evt), .wdog_evt(wdog_evt), .pwr_oe(pwr_oe),
    .pwr_out(pwr_out), .irq_oe(irq_oe), .xfer_en(xfer_en),
    .burst_en(burst_en), .xtal_sel(xtal_sel)
  );

  // monitor: pops one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        if (it.kind == 2) act = {4'b0, pwr_oe, irq_oe, xfer_en, burst_en};
        else              act = rd_data;
        if (it.kind == 2 && pwr_out !== 1'b0) act = 8'hFF;  // R3 pwr_out constant
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(posedge clk); #1;
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ev(input bit a, input bit k, input bit w, input bit dw, input logic [7:0] d);
    @(posedge clk); #1;
    alarm_evt = a; kick_evt = k; wdog_evt = w;
    if (dw) begin reg_sel = 1'b0; wr_data = d; wr_en = 1'b1; end
    @(posedge clk); #1;
    alarm_evt = 1'b0; kick_evt = 1'b0; wdog_evt = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    if (kind != 2) reg_sel = (kind == 1);
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(0, 8'h10, "R1");
    chk(1, 8'h80, "R1");
    chk(2, 8'h02, "R1");
    wr(1, 8'hBF);            chk(1, 8'hB7, "R2");
    chk(2, 8'h03, "R8");
    wr(1, 8'h80);
    wr(0, 8'h11);            chk(0, 8'h10, "R9");
    wr(0, 8'h00);            chk(0, 8'h00, "R3"); chk(2, 8'h0A, "R3");
    wr(0, 8'h10);            chk(2, 8'h02, "R3");
    ev(0, 0, 1, 0, 8'h00);   chk(0, 8'h12, "R4"); chk(2, 8'h02, "R6");
    wr(1, 8'h81);            chk(0, 8'h13, "R6"); chk(2, 8'h06, "R6");
    wr(0, 8'h10);            chk(0, 8'h10, "R7");
    wr(1, 8'h80);
    ev(1, 0, 0, 0, 8'h00);   chk(0, 8'h18, "R5");
    wr(1, 8'h90);            chk(0, 8'h08, "R5"); chk(2, 8'h0A, "R5");
    wr(0, 8'h10);            chk(0, 8'h00, "R5");
    wr(0, 8'h10);            chk(0, 8'h10, "R3");
    wr(1, 8'h80);
    ev(1, 0, 1, 1, 8'h10);   chk(0, 8'h1A, "R4");   // event beats clearing write
    wr(0, 8'h10);            chk(0, 8'h10, "R7");
    ev(0, 1, 0, 0, 8'h00);   chk(0, 8'h04, "R5"); chk(2, 8'h0A, "R5");
    wr(0, 8'h14);            chk(0, 8'h04, "R5");   // hw clear beats sw set
    wr(0, 8'h10);            chk(0, 8'h00, "R5");
    wr(0, 8'h10);            chk(0, 8'h10, "R3");
    wr(0, 8'h14);            chk(0, 8'h04, "R7");
    wr(1, 8'h82);            chk(0, 8'h05, "R6"); chk(2, 8'h0E, "R6");
    wr(0, 8'h00);            chk(0, 8'h00, "R7"); chk(2, 8'h0A, "R6");
    wr(0, 8'h10);
    wr(1, 8'h04);            chk(2, 8'h00, "R8");
    ev(1, 1, 1, 0, 8'h00);   chk(0, 8'h0F, "R6"); chk(1, 8'h04, "R8");
    chk(2, 8'h0C, "R6");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired before end of sequence");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule